// File: doc/BRIEF.md
# Channel Control Register with LED Blink Generators

This block holds the single 8-bit control register of a two-channel interface card. Three things are decoded from it. The first is a 2-bit clock-frequency selection for the channel controllers. The second is one active-high reset line per channel. The third is a 2-bit display mode per channel, which drives an LED output. Software writes the whole register in one access and can read it back unchanged.

Each LED output is steady on, blinks fast, blinks slow or stays dark, according to its mode field. The two blink rates come from one shared free-running prescaler. Writing a new mode never restarts the blink phase. After reset both channels are held in reset with their LEDs dark. The usual bring-up writes the reset value, waits at least 2 ms, and then clears the two reset bits. The block accepts this sequence with no effect beyond the bits that change.

Each LED driver is a small decoder whose state is the mode field, named by the enumeration `led_mode_e`. `LED_STEADY` (00) drives the LED high. `LED_FAST` (01) follows the fast phase. `LED_SLOW` (10) follows the slow phase. `LED_DARK` (11) drives the LED low. The driver moves from one state to another only by a register write, on the clock edge that takes the write. There are no other transitions.

Top module: `chanctl_reg`

## Requirements
- R1: After reset `rd_data` is 0xFC. `clk_sel` is 00 (the 16 MHz setting), `chan_rst` is 11 and `led` is 00.
- R2: `rd_data` returns exactly the last value written, from the clock edge that takes the write.
- R3: `clk_sel` equals register bits [1:0]. The encodings are 00 for 16 MHz, 01 for 10 MHz, 10 for 21 MHz and 11 for 8 MHz.
- R4: `chan_rst[c]` equals register bit 2+c. A channel is held in reset while its bit is 1.
- R5: The LED mode of channel c sits in bits [(c+2)*2+1:(c+2)*2], that is [5:4] for channel 0 and [7:6] for channel 1. Mode 00 drives `led[c]` high and mode 11 drives it low. `led` is active high.
- R6: Mode 01 makes `led[c]` equal the fast phase. The fast phase starts at 0 when reset is released and toggles every FAST_HALF_CYC clock cycles.
- R7: Mode 10 makes `led[c]` equal the slow phase. The slow phase starts at 0 when reset is released and toggles every FAST_HALF_CYC*SLOW_RATIO clock cycles.
- R8: A write changes the outputs one clock later, on the edge that takes it. It neither restarts nor shifts the phase of either blink rate.
- R9: While `wr_en` is 0, `wr_data` has no effect on the register or on any output.
- R10: Writing 0xF0 after the reset value has been held clears both channel resets. `clk_sel` stays 00 and both LEDs stay dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Value to write |
| rd_data | output | 8 | Current register value |
| clk_sel | output | 2 | Controller clock-frequency selection |
| chan_rst | output | 2 | Active-high per-channel reset |
| led | output | 2 | Active-high per-channel LED drive |

## Verification
The assertions assume that `wr_en` and `wr_data` carry known values at every rising edge once reset is released. They also assume that reset is held across at least one edge before the first write. The stimulus meets both assumptions. It drives every input only at the falling edge, from defined initial values, and it keeps `wr_en` low through reset. The blink checks compare against a cycle count taken in the bench from the release of reset. The bench count does not depend on any write, so an unwanted phase restart shows up as a mismatch.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;

    // Per-channel LED mode: 2-bit field, 00 = on, 11 = off
    typedef enum logic [1:0] {
        LED_STEADY = 2'b00,
        LED_FAST   = 2'b01,
        LED_SLOW   = 2'b10,
        LED_DARK   = 2'b11
    } led_mode_e;

    // Controller clock selection, register bits [1:0]
    typedef enum logic [1:0] {
        CLK_16M = 2'b00,
        CLK_10M = 2'b01,
        CLK_21M = 2'b10,
        CLK_8M  = 2'b11
    } clk_sel_e;

    localparam int CLK_FIELD_W = 2;
    localparam int LED_FIELD_W = 2;

endpackage

// File: rtl/chanctl_prescaler.sv
module chanctl_prescaler #(
    parameter int FAST_HALF_CYC = 12_500_000,
    parameter int SLOW_RATIO    = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic fast_ph,
    output logic slow_ph
);
    localparam int CW = $clog2(FAST_HALF_CYC + 1);
    localparam int SW = $clog2(SLOW_RATIO + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FAST_HALF_CYC - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SLOW_RATIO - 1);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] sub_q;
    logic          fast_wrap;
    logic          slow_wrap;

    assign fast_wrap = (cnt_q == CNT_LAST);
    assign slow_wrap = fast_wrap && (sub_q == SUB_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fast_wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (slow_wrap) begin
            sub_q <= '0;
        end else if (fast_wrap) begin
            sub_q <= sub_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fast_ph <= 1'b0;
            slow_ph <= 1'b0;
        end else begin
            if (fast_wrap) fast_ph <= ~fast_ph;
            if (slow_wrap) slow_ph <= ~slow_ph;
        end
    end

endmodule

// File: rtl/chanctl_led_drv.sv
module chanctl_led_drv
    import chanctl_pkg::*;
(
    input  led_mode_e mode,
    input  logic      fast_ph,
    input  logic      slow_ph,
    output logic      led_o
);
    always_comb begin
        unique case (mode)
            LED_STEADY: led_o = 1'b1;
            LED_FAST:   led_o = fast_ph;
            LED_SLOW:   led_o = slow_ph;
            LED_DARK:   led_o = 1'b0;
            default:    led_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/chanctl_ccr_reg.sv
module chanctl_ccr_reg #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

endmodule

// File: rtl/chanctl_reg.sv
module chanctl_reg
    import chanctl_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int FAST_HALF_CYC = 12_500_000,
    parameter int SLOW_RATIO    = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic [CLK_FIELD_W+NUM_CH*(1+LED_FIELD_W)-1:0] wr_data,
    output logic [CLK_FIELD_W+NUM_CH*(1+LED_FIELD_W)-1:0] rd_data,
    output logic [CLK_FIELD_W-1:0]                   clk_sel,
    output logic [NUM_CH-1:0]                        chan_rst,
    output logic [NUM_CH-1:0]                        led
);
    localparam int REG_W   = CLK_FIELD_W + NUM_CH * (1 + LED_FIELD_W);
    localparam int RST_LSB = CLK_FIELD_W;
    localparam int LED_LSB = CLK_FIELD_W + NUM_CH;
    // Reset value: 16 MHz, every channel in reset, every LED dark
    localparam logic [REG_W-1:0] RST_VAL =
        {{(NUM_CH*LED_FIELD_W){1'b1}}, {NUM_CH{1'b1}}, CLK_16M};

    logic [REG_W-1:0] ccr_q;
    logic             fast_ph;
    logic             slow_ph;

    chanctl_ccr_reg #(
        .W       (REG_W),
        .RST_VAL (RST_VAL)
    ) u_ccr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .q       (ccr_q)
    );

    chanctl_prescaler #(
        .FAST_HALF_CYC (FAST_HALF_CYC),
        .SLOW_RATIO    (SLOW_RATIO)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_ph (fast_ph),
        .slow_ph (slow_ph)
    );

    assign rd_data  = ccr_q;
    assign clk_sel  = ccr_q[CLK_FIELD_W-1:0];
    assign chan_rst = ccr_q[RST_LSB +: NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_led
        led_mode_e mode_c;
        assign mode_c = led_mode_e'(ccr_q[LED_LSB + LED_FIELD_W*c +: LED_FIELD_W]);

        chanctl_led_drv u_drv (
            .mode    (mode_c),
            .fast_ph (fast_ph),
            .slow_ph (slow_ph),
            .led_o   (led[c])
        );
    end

endmodule

// File: rtl/chanctl_reg_chk.sv
module chanctl_reg_chk #(
    parameter int NUM_CH = 2,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic [1:0]        clk_sel,
    input logic [NUM_CH-1:0] chan_rst,
    input logic [NUM_CH-1:0] led
);
    localparam int LED_LSB = 2 + NUM_CH;

    // R2: a write is visible on the read port after the edge
    p_rdback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    // R9: no write strobe, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R3: clock selection follows the written field
    p_clksel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (clk_sel == $past(wr_data[1:0])));

    // R4: channel resets follow the written bits
    p_chrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (chan_rst == $past(wr_data[2 +: NUM_CH])));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R5: mode 00 lights the LED, mode 11 darkens it
        p_led_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[LED_LSB + 2*c +: 2] == 2'b00) |-> led[c]);
        p_led_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[LED_LSB + 2*c +: 2] == 2'b11) |-> !led[c]);
    end

endmodule

bind chanctl_reg chanctl_reg_chk #(
    .NUM_CH (NUM_CH),
    .REG_W  (REG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .clk_sel  (clk_sel),
    .chan_rst (chan_rst),
    .led      (led)
);

// File: tb/chanctl_reg_bench.sv
module chanctl_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FH = 4;
    localparam int SR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [1:0] clk_sel;
    logic [1:0] chan_rst;
    logic [1:0] led;

    int  tests = 0;
    int  fails = 0;
    bit  done = 0;
    int  n_edges = 0;
    logic [7:0] model = 8'hFC;

    typedef struct {
        logic [7:0] rd;
        logic [1:0] cs;
        logic [1:0] rs;
        logic [1:0] ld;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chanctl_reg #(
        .NUM_CH        (2),
        .FAST_HALF_CYC (FH),
        .SLOW_RATIO    (SR)
    ) u_chanctl_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .clk_sel  (clk_sel),
        .chan_rst (chan_rst),
        .led      (led)
    );

    // Edges since reset release: drives the bench's own blink phases
    always @(posedge clk) begin
        if (!rst_n) n_edges <= 0;
        else        n_edges <= n_edges + 1;
    end

    function automatic logic led_of(logic [1:0] m, int n);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return 1'((n / FH) % 2);
            2'b10:   return 1'((n / (FH*SR)) % 2);
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_exp(string tag);
        exp_t e;
        e.rd  = model;
        e.cs  = model[1:0];
        e.rs  = model[3:2];
        e.ld  = {led_of(model[7:6], n_edges), led_of(model[5:4], n_edges)};
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Driver: call at a falling edge; returns at the next falling edge
    task automatic wr(logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = ~v;
        model   = v;
    endtask

    task automatic idle_check(int cycles, string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            push_exp(tag);
        end
    endtask

    // Monitor: pops expectations and compares with the outputs
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb_q.pop_front();
            tests++;
            bad = 0;
            if (rd_data !== e.rd) begin
                $display("FAIL %s rd_data act=%h exp=%h", e.tag, rd_data, e.rd); bad = 1;
            end
            if (clk_sel !== e.cs) begin
                $display("FAIL %s clk_sel act=%b exp=%b", e.tag, clk_sel, e.cs); bad = 1;
            end
            if (chan_rst !== e.rs) begin
                $display("FAIL %s chan_rst act=%b exp=%b", e.tag, chan_rst, e.rs); bad = 1;
            end
            if (led !== e.ld) begin
                $display("FAIL %s led act=%b exp=%b at edge %0d", e.tag, led, e.ld, n_edges); bad = 1;
            end
            if (bad) fails++;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_check(3, "R1 reset state");

        // Bring-up: rewrite reset value, hold, then release resets
        wr(8'hFC);
        push_exp("R2 rewrite reset value");
        idle_check(20, "R10 hold before release");
        wr(8'hF0);
        push_exp("R10 release resets");
        idle_check(2, "R10 after release");

        // Clock selection encodings
        wr(8'hF1); push_exp("R3 clk 10M");
        wr(8'hF2); push_exp("R3 clk 21M");
        wr(8'hF3); push_exp("R3 clk 8M");
        wr(8'hF0); push_exp("R3 clk 16M");

        // Channel resets individually
        wr(8'hF4); push_exp("R4 reset ch0 only");
        wr(8'hF8); push_exp("R4 reset ch1 only");

        // LED on/off field positions
        wr(8'h30); push_exp("R5 ch0 dark ch1 on");
        wr(8'hC0); push_exp("R5 ch0 on ch1 dark");
        wr(8'h00); push_exp("R5 both on");

        // Fast blink both channels
        wr(8'h50);
        push_exp("R6 fast write edge");
        idle_check(14, "R6 fast blink");

        // Slow blink both channels
        wr(8'hA0);
        push_exp("R7 slow write edge");
        idle_check(40, "R7 slow blink");

        // Mixed modes written mid-phase: phase must not restart
        @(negedge clk);
        wr(8'h90);
        push_exp("R8 mixed write next edge");
        idle_check(9, "R8 phase continuity");
        wr(8'h60);
        push_exp("R8 swapped modes");
        idle_check(7, "R8 phase continuity swapped");

        // Arbitrary readback values
        wr(8'h5A); push_exp("R2 readback 5A");
        wr(8'hA5); push_exp("R2 readback A5");

        // Data toggling with no strobe
        for (int i = 0; i < 8; i++) begin
            wr_data = 8'(i * 37 + 3);
            @(negedge clk);
            push_exp("R9 ignored data");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule